// File: doc/BRIEF.md
# Three-Level Nested Interrupt Priority Arbiter

This block sits between the interrupt request lines of a small processor's peripherals and the processor core. Requests are grouped into ten vector slots, several sources per slot. Each slot runs at one of three priority levels: low, high or highest. The arbiter picks one slot, raises an interrupt request to the core and presents the slot's vector address. It keeps that choice fixed until the core acknowledges it.

An internal stack records the levels of the interrupts now in service, so interrupts can nest. A pending request interrupts the running handler only when its level is strictly above the level in service. When the core signals a return from a handler, the previous level comes back into force. Requests held off until then are taken at that point.

Top module: `irq_arb`

## Requirements
- R1: After reset `irq` is 0, `vec_addr` is 0x00 and no level is in service, so a request of any level is accepted.
- R2: Slot i (0 to 9) presents vector address 0x03 + 8*i: 0x03, 0x0B, 0x13, ... 0x4B.
- R3: Slot i requests whenever either of its source lines `src_req[2*i]` or `src_req[2*i+1]` is high. Requests are level-sensitive.
- R4: `lvl_hi[i]` = 1 puts slot i at its upper level, and 0 puts it at low. The upper level is highest for slots 0 and 1, and high for slots 2 to 9.
- R5: Among requests that can be accepted, the one at the higher level wins.
- R6: Among eligible requests at the same level, the slot with the smallest vector address wins.
- R7: While an interrupt is in service, a request whose level is equal to or below the level in service raises no `irq`.
- R8: A request at a level strictly above the level in service is accepted, so handlers nest up to three deep.
- R9: From the cycle `irq` rises until the acknowledge, `irq` stays high and `vec_addr` stays unchanged, even if the requests change.
- R10: An `ack` while `irq` is high drops `irq` at the next clock and puts the acknowledged level in service. A `reti` pulse takes that level out of service and restores the previous one.
- R11: A `reti` with nothing in service, and an `ack` while `irq` is low, have no effect.
- R12: When the arbiter is idle, `irq` rises at the first clock edge that samples an eligible request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 20 | Request lines, two per slot (slot i owns bits 2i and 2i+1) |
| lvl_hi | input | 10 | Per-slot level choice: 1 = upper level, 0 = low |
| ack | input | 1 | Core acknowledges the presented interrupt |
| reti | input | 1 | Core returns from the current handler |
| irq | output | 1 | Interrupt request to the core |
| vec_addr | output | 8 | Vector address of the chosen slot |

## Verification
The arbiter is driven with a lone low request through the second source line of a slot. The lone request shows vector mapping and one-cycle latency. A simultaneous set of high and low requests separates the level comparison from the index tie-break. Equal-level and higher-level requests made during service separate strict from non-strict nesting. Requests dropped while `irq` is pending show that the presented vector is latched and not re-chosen.

A run of `reti` pulses replays the held-off requests in level order, then in index order. That run shows the stack restoring each earlier level. Stray `reti` and `ack` pulses are followed by a low request that is still accepted, which shows they changed nothing.

// File: rtl/irq_arb_pkg.sv
// Package: shared level type for the nested interrupt arbiter.
// Assumes levels are compared as unsigned numbers (higher value = more urgent).
package irq_arb_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,   // nothing in service
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_TOP  = 2'd3
    } lvl_e;

endpackage

// File: rtl/irq_slot_merge.sv
// Module: irq_slot_merge
// Folds the source lines of each slot into one request and turns the slot's
// one-bit level choice into a level. The first NUM_TOP_SLOTS slots choose
// between the highest and low levels; the rest choose between high and low.
// Assumes the sources of slot i sit at src_req[i*SRC_PER_SLOT +: SRC_PER_SLOT].
module irq_slot_merge
    import irq_arb_pkg::*;
#(
    parameter int NUM_SLOTS     = 10,
    parameter int SRC_PER_SLOT  = 2,
    parameter int NUM_TOP_SLOTS = 2
) (
    input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0] src_req,
    input  logic [NUM_SLOTS-1:0]              lvl_hi,
    output logic [NUM_SLOTS-1:0]              slot_req,
    output lvl_e [NUM_SLOTS-1:0]              slot_lvl
);

    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
        // OR the shared sources of this slot together.
        assign slot_req[gi] = |src_req[gi*SRC_PER_SLOT +: SRC_PER_SLOT];

        if (gi < NUM_TOP_SLOTS) begin : g_top
            // Top-capable slot: highest or low.
            assign slot_lvl[gi] = lvl_hi[gi] ? LVL_TOP : LVL_LOW;
        end else begin : g_norm
            // Ordinary slot: high or low.
            assign slot_lvl[gi] = lvl_hi[gi] ? LVL_HIGH : LVL_LOW;
        end
    end

endmodule

// File: rtl/irq_pick.sv
// Module: irq_pick
// Chooses, among requesting slots whose level is strictly above floor_lvl,
// the one with the highest level; ties go to the lowest slot index.
// Purely combinational. Assumes slot index 0 holds the smallest vector.
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] slot_req,
    input  lvl_e [NUM_SLOTS-1:0] slot_lvl,
    input  lvl_e                 floor_lvl,
    output logic                 pick_vld,
    output logic [IDX_W-1:0]     pick_idx,
    output lvl_e                 pick_lvl
);

    // Scan upward; a strictly greater level replaces the best so far,
    // so the lowest index keeps the win on equal levels.
    always_comb begin
        pick_vld = 1'b0;
        pick_idx = '0;
        pick_lvl = floor_lvl;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_req[i] && (slot_lvl[i] > pick_lvl)) begin
                pick_vld = 1'b1;
                pick_idx = IDX_W'(i);
                pick_lvl = slot_lvl[i];
            end
        end
    end

endmodule

// File: rtl/irq_lvl_stack.sv
// Module: irq_lvl_stack
// Small stack of in-service levels. top_lvl is the newest entry, or LVL_NONE
// when empty. push and pop in the same cycle replace the top entry.
// A pop on an empty stack is ignored; the caller guarantees no push when full.
module irq_lvl_stack
    import irq_arb_pkg::*;
#(
    parameter int DEPTH    = 3,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  lvl_e push_lvl,
    input  logic pop,
    output lvl_e top_lvl
);

    logic [CNT_W-1:0] cnt;
    lvl_e             mem [DEPTH];
    logic             pop_ok;
    logic             push_ok;

    assign pop_ok  = pop && (cnt != '0);
    assign push_ok = push && ((cnt != CNT_W'(DEPTH)) || pop_ok);

    // Occupancy count: up on a push, down on a pop, unchanged on both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push_ok && !pop_ok) begin
            cnt <= cnt + 1'b1;
        end else if (pop_ok && !push_ok) begin
            cnt <= cnt - 1'b1;
        end
    end

    for (genvar ge = 0; ge < DEPTH; ge++) begin : g_ent
        logic wr_en;
        // Entry ge is written by a plain push at depth ge or a replace at ge+1.
        assign wr_en = (push_ok && !pop_ok && (cnt == CNT_W'(ge)))
                    || (push_ok && pop_ok && (cnt == CNT_W'(ge + 1)));

        // Storage for one nested level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[ge] <= LVL_NONE;
            end else if (wr_en) begin
                mem[ge] <= push_lvl;
            end
        end
    end

    // Present the newest level, or none when empty.
    always_comb begin
        if (cnt == '0) begin
            top_lvl = LVL_NONE;
        end else begin
            top_lvl = mem[cnt - 1'b1];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && (cnt == CNT_W'(DEPTH)))); // R8

    AST_LEVEL_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (push_lvl > top_lvl)); // R8

    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && (cnt == '0)) |=> (cnt == '0)); // R11

endmodule

// File: rtl/irq_arb.sv
// Module: irq_arb (top)
// Nested three-level interrupt arbiter. Merges sources into slots, picks the
// best slot above the level in service, and latches its vector until the
// core acknowledges. ack pushes the latched level; reti pops it.
// Assumes ack is only meaningful while irq is high.
module irq_arb
    import irq_arb_pkg::*;
#(
    parameter int NUM_SLOTS     = 10,
    parameter int SRC_PER_SLOT  = 2,
    parameter int NUM_TOP_SLOTS = 2,
    parameter int STACK_DEPTH   = 3,
    parameter int VEC_BASE      = 3,
    parameter int VEC_STRIDE    = 8,
    parameter int VEC_W         = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0] src_req,
    input  logic [NUM_SLOTS-1:0]              lvl_hi,
    input  logic                              ack,
    input  logic                              reti,
    output logic                              irq,
    output logic [VEC_W-1:0]                  vec_addr
);

    localparam int IDX_W = $clog2(NUM_SLOTS);

    logic [NUM_SLOTS-1:0] slot_req;
    lvl_e [NUM_SLOTS-1:0] slot_lvl;
    lvl_e                 cur_lvl;
    logic                 pick_vld;
    logic [IDX_W-1:0]     pick_idx;
    lvl_e                 pick_lvl;
    logic [VEC_W-1:0]     pick_vec;
    logic                 irq_q;
    logic [VEC_W-1:0]     vec_q;
    lvl_e                 lvl_q;
    logic                 take_ack;

    irq_slot_merge #(
        .NUM_SLOTS     (NUM_SLOTS),
        .SRC_PER_SLOT  (SRC_PER_SLOT),
        .NUM_TOP_SLOTS (NUM_TOP_SLOTS)
    ) u_merge (
        .src_req  (src_req),
        .lvl_hi   (lvl_hi),
        .slot_req (slot_req),
        .slot_lvl (slot_lvl)
    );

    irq_pick #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_pick (
        .slot_req  (slot_req),
        .slot_lvl  (slot_lvl),
        .floor_lvl (cur_lvl),
        .pick_vld  (pick_vld),
        .pick_idx  (pick_idx),
        .pick_lvl  (pick_lvl)
    );

    assign take_ack = irq_q && ack;

    irq_lvl_stack #(
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take_ack),
        .push_lvl (lvl_q),
        .pop      (reti),
        .top_lvl  (cur_lvl)
    );

    // Vector address of the chosen slot: base plus index times stride.
    assign pick_vec = VEC_W'(VEC_BASE + VEC_STRIDE * int'(pick_idx));

    // Request register: raise on an eligible pick, hold until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= '0;
            lvl_q <= LVL_NONE;
        end else if (irq_q) begin
            if (ack) begin
                irq_q <= 1'b0;
            end
        end else if (pick_vld) begin
            irq_q <= 1'b1;
            vec_q <= pick_vec;
            lvl_q <= pick_lvl;
        end
    end

    assign irq      = irq_q;
    assign vec_addr = vec_q;

    AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack) |=> (irq_q && $stable(vec_q))); // R9

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && ack) |=> !irq_q); // R10

    AST_IDLE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q && pick_vld) |=> irq_q); // R12

    AST_PICK_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |-> (slot_req[pick_idx] && (slot_lvl[pick_idx] > cur_lvl))); // R7

endmodule

// File: tb/irq_arb_tb.sv
module irq_arb_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] src_req = '0;
    logic [9:0]  lvl_hi = '0;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq;
    logic [7:0]  vec_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit irq_prev = 1'b0;

    int unsigned exp_vec[$];
    string       exp_tag[$];

    always #5 clk = ~clk;

    irq_arb u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .lvl_hi   (lvl_hi),
        .ack      (ack),
        .reti     (reti),
        .irq      (irq),
        .vec_addr (vec_addr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard: the next irq rise must carry this vector.
    task automatic expect_vec(input int unsigned v, input string tag);
        exp_vec.push_back(v);
        exp_tag.push_back(tag);
    endtask

    // Monitor: on each irq rise, pop the expected vector and compare.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq && !irq_prev) begin
                if (exp_vec.size() == 0) begin
                    check(1'b0, "unexpected irq", int'(vec_addr), 0);
                end else begin
                    int unsigned ev;
                    string       et;
                    ev = exp_vec.pop_front();
                    et = exp_tag.pop_front();
                    check(vec_addr == 8'(ev), et, int'(vec_addr), int'(ev));
                end
            end
            irq_prev <= irq;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_slot(input int s, input int line, input bit v);
        src_req[2*s + line] = v;
    endtask

    // Acknowledge the pending request; irq must be low one clock later (R10).
    task automatic do_ack();
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        check(irq == 1'b0, "R10 irq drop after ack", int'(irq), 0);
    endtask

    task automatic do_reti();
        reti = 1'b1;
        cyc(1);
        reti = 1'b0;
    endtask

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
        check(vec_addr == 8'h00, "R1 vec after reset", int'(vec_addr), 0);

        // Lone low request on second source line of slot 5.
        expect_vec(32'h2B, "R2 R3 slot5 vector");
        set_slot(5, 1, 1'b1);
        cyc(1);
        check(irq == 1'b1, "R12 one-cycle raise", int'(irq), 1);
        cyc(1);
        do_ack();
        cyc(3);
        check(irq == 1'b0, "R7 same slot held at own level", int'(irq), 0);
        set_slot(5, 1, 1'b0);
        do_reti();
        cyc(2);

        // Simultaneous mix: slot3 high, slots 1 and 7 low.
        lvl_hi = 10'b10_0000_1001;   // slot0 X, slot3 H, slot9 H
        expect_vec(32'h1B, "R5 high beats low");
        set_slot(3, 0, 1'b1);
        set_slot(1, 0, 1'b1);
        set_slot(7, 1, 1'b1);
        cyc(2);
        do_ack();
        set_slot(9, 0, 1'b1);
        cyc(3);
        check(irq == 1'b0, "R7 equal high held off", int'(irq), 0);
        expect_vec(32'h03, "R8 highest nests over high");
        set_slot(0, 0, 1'b1);
        cyc(1);
        check(irq == 1'b1, "R8 nested raise", int'(irq), 1);
        set_slot(0, 0, 1'b0);
        set_slot(2, 1, 1'b1);
        cyc(2);
        check(irq == 1'b1 && vec_addr == 8'h03, "R9 vector held", int'(vec_addr), 3);
        do_ack();
        set_slot(3, 0, 1'b0);
        do_reti();
        cyc(3);
        check(irq == 1'b0, "R10 restored high still blocks", int'(irq), 0);
        expect_vec(32'h4B, "R10 R5 after return high slot9");
        do_reti();
        cyc(2);
        do_ack();
        set_slot(9, 0, 1'b0);
        expect_vec(32'h0B, "R6 low tie lowest index");
        do_reti();
        cyc(2);
        do_ack();
        set_slot(1, 0, 1'b0);
        set_slot(2, 1, 1'b0);
        set_slot(7, 1, 1'b0);
        do_reti();
        cyc(2);
        check(irq == 1'b0, "R10 all returned idle", int'(irq), 0);

        // Stray return and acknowledge pulses must change nothing.
        do_reti();
        do_reti();
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        check(irq == 1'b0, "R11 stray ack no irq", int'(irq), 0);
        expect_vec(32'h23, "R11 low still accepted");
        set_slot(4, 0, 1'b1);
        cyc(2);
        do_ack();
        set_slot(4, 0, 1'b0);
        do_reti();
        cyc(2);

        // Level mapping of a top-capable slot.
        lvl_hi = 10'b00_0000_0100;  // slot2 H, slot0 L
        expect_vec(32'h13, "R4 slot2 at high");
        set_slot(2, 0, 1'b1);
        cyc(2);
        do_ack();
        set_slot(0, 1, 1'b1);
        cyc(3);
        check(irq == 1'b0, "R4 slot0 low blocked under high", int'(irq), 0);
        expect_vec(32'h03, "R4 slot0 upper is highest");
        lvl_hi[0] = 1'b1;
        cyc(2);
        do_ack();
        set_slot(0, 1, 1'b0);
        set_slot(2, 0, 1'b0);
        do_reti();
        do_reti();
        cyc(3);
        check(irq == 1'b0, "R10 idle at end", int'(irq), 0);
        check(exp_vec.size() == 0, "R2 scoreboard drained", exp_vec.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule